// File: doc/BRIEF.md
# Four-Channel LIN Transmit Permission Gate

This block decides, on every clock cycle and for each of four LIN channels, whether the line driver may pull that bus dominant. Each channel follows its synchronous transmit-data input. It drives only while that input is Low, only after the input has shown a High-to-Low edge since normal mode began, and only for a bounded number of cycles before its own watchdog lets the bus return to recessive. A channel that is stuck dominant never affects the other three.

Chip-wide conditions gate all channels together. Thermal shutdown blocks every driver and forces the receive outputs Low, and it releases both in the same cycle that the flag clears. A battery monitor with two comparator flags blocks transmission from the low-threshold flag until the recovered-threshold flag is seen. Battery blocking leaves reception untouched. The mode controller's normal-mode level enables the whole block.

Top module: `lin_tx_gate`

## Requirements
- R1: The four channels are independent: a channel held Low past its timeout neither stops nor delays driving on any other channel.
- R2: A channel drives only while its TxD is Low, and only after a High-to-Low TxD transition seen in normal mode; TxD already Low when normal mode starts never drives until TxD has gone High and then Low.
- R3: Starting in the cycle of the falling edge, a channel drives for at most TIMEOUT_CYC consecutive cycles of Low TxD and is then released to recessive (drive bit 0) while TxD stays Low.
- R4: After a timeout, a channel drives again from the cycle of its next High-to-Low TxD transition.
- R5: While therm_sd_i is 1, every drive bit is 0 and rxd_force_low_o is 1; both release in the same cycle that therm_sd_i returns to 0, and transmission resumes at once.
- R6: batt_low_i blocks all driving in the same cycle it is 1. The block then persists until a cycle with batt_ok_i 1 and batt_low_i 0, and driving is allowed from the following cycle.
- R7: Battery blocking never asserts rxd_force_low_o.
- R8: When normal_i is 0, every drive bit is 0.
- R9: During and right after reset, every drive bit is 0, the battery block is clear, and rxd_force_low_o follows therm_sd_i.
- R10: A new falling edge on a channel restarts that channel's timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active Low |
| normal_i | input | 1 | Normal-mode level from the mode controller |
| txd_i | input | N_CH | Synchronous TxD per channel, bit n is channel n |
| therm_sd_i | input | 1 | Thermal shutdown flag |
| batt_low_i | input | 1 | Battery below the low threshold |
| batt_ok_i | input | 1 | Battery above the recovery threshold |
| drv_dom_o | output | N_CH | Drive-dominant enable per channel, 1 = pull bus dominant |
| rxd_force_low_o | output | 1 | Force all RxD outputs Low |

## Verification
The checker checks these on every cycle: no drive outside normal mode, under thermal shutdown or while batt_low_i is high; no drive while TxD is High; no drive run longer than the timeout; no drive on a Low TxD at normal-mode entry; and the RxD force flag tracking the thermal flag. Only the bench's scenarios show that the hysteresis holds the block across cycles where neither battery flag is set, that driving resumes right after a timeout or a fault clears, and that a channel stuck Low leaves a neighbour's edges fully served.

// File: rtl/lin_gate_pkg.sv
package lin_gate_pkg;
  typedef enum logic {
    CH_IDLE  = 1'b0,
    CH_DRIVE = 1'b1
  } ch_state_e;

  typedef struct packed {
    logic therm;
    logic bat_blk;
  } fault_t;
endpackage

// File: rtl/lin_batt_hyst.sv
module lin_batt_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic batt_low_i,
  input  logic batt_ok_i,
  output logic blocked_o
);
  logic blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        blk_q <= 1'b0;
    else if (batt_low_i) blk_q <= 1'b1;
    else if (batt_ok_i)  blk_q <= 1'b0;
  end

  // low flag blocks at once; release waits for the registered clear
  assign blocked_o = batt_low_i | blk_q;
endmodule

// File: rtl/lin_fault_gate.sv
module lin_fault_gate
  import lin_gate_pkg::*;
(
  input  logic   normal_i,
  input  fault_t fault_i,
  output logic   permit_o,
  output logic   rxd_force_low_o
);
  assign permit_o        = normal_i & ~fault_i.therm & ~fault_i.bat_blk;
  assign rxd_force_low_o = fault_i.therm;
endmodule

// File: rtl/lin_tx_chan.sv
module lin_tx_chan
  import lin_gate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2000,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic permit_i,
  input  logic txd_i,
  output logic drv_o
);
  logic          txd_prev_q;
  ch_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          fall;

  // prev forced Low outside normal: a Low TxD at entry cannot arm
  assign fall = normal_i & txd_prev_q & ~txd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_prev_q <= 1'b0;
      state_q    <= CH_IDLE;
      cnt_q      <= '0;
    end else begin
      txd_prev_q <= normal_i & txd_i;
      if (!normal_i) begin
        state_q <= CH_IDLE;
        cnt_q   <= '0;
      end else if (fall) begin
        state_q <= CH_DRIVE;
        cnt_q   <= CW'(1);
      end else if (txd_i) begin
        state_q <= CH_IDLE;
        cnt_q   <= '0;
      end else if (state_q == CH_DRIVE) begin
        if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
          state_q <= CH_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign drv_o = permit_i & normal_i & ~txd_i & (fall | (state_q == CH_DRIVE));
endmodule

// File: rtl/lin_tx_gate.sv
module lin_tx_gate
  import lin_gate_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            normal_i,
  input  logic [N_CH-1:0] txd_i,
  input  logic            therm_sd_i,
  input  logic            batt_low_i,
  input  logic            batt_ok_i,
  output logic [N_CH-1:0] drv_dom_o,
  output logic            rxd_force_low_o
);
  logic   bat_blk;
  logic   permit;
  fault_t fault;

  lin_batt_hyst u_batt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .batt_low_i (batt_low_i),
    .batt_ok_i  (batt_ok_i),
    .blocked_o  (bat_blk)
  );

  assign fault.therm   = therm_sd_i;
  assign fault.bat_blk = bat_blk;

  lin_fault_gate u_fault (
    .normal_i        (normal_i),
    .fault_i         (fault),
    .permit_o        (permit),
    .rxd_force_low_o (rxd_force_low_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    lin_tx_chan #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .normal_i (normal_i),
      .permit_i (permit),
      .txd_i    (txd_i[g]),
      .drv_o    (drv_dom_o[g])
    );
  end
endmodule

// File: rtl/lin_tx_gate_chk.sv
module lin_tx_gate_chk #(
  parameter int N_CH        = 4,
  parameter int TIMEOUT_CYC = 2000,
  localparam int RW = $clog2(TIMEOUT_CYC + 2)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            normal_i,
  input logic [N_CH-1:0] txd_i,
  input logic            therm_sd_i,
  input logic            batt_low_i,
  input logic            batt_ok_i,
  input logic [N_CH-1:0] drv_dom_o,
  input logic            rxd_force_low_o
);
  // R8
  no_drive_outside_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_i |-> drv_dom_o == '0);

  // R5
  therm_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_sd_i |-> (drv_dom_o == '0) && rxd_force_low_o);

  // R7
  rxd_only_thermal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !therm_sd_i |-> !rxd_force_low_o);

  // R6
  batt_low_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_low_i |-> drv_dom_o == '0);

  for (genvar g = 0; g < N_CH; g++) begin : g_c
    logic [RW-1:0] run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          run_q <= '0;
      else if (drv_dom_o[g]) run_q <= run_q + RW'(1);
      else                   run_q <= '0;
    end

    // R2
    drive_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_dom_o[g] |-> !txd_i[g]);

    // R2
    low_at_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(normal_i) && !txd_i[g]) |-> !drv_dom_o[g]);

    // R3
    timeout_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_dom_o[g] |-> run_q < RW'(TIMEOUT_CYC));
  end
endmodule

bind lin_tx_gate lin_tx_gate_chk #(.N_CH(N_CH), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .normal_i        (normal_i),
  .txd_i           (txd_i),
  .therm_sd_i      (therm_sd_i),
  .batt_low_i      (batt_low_i),
  .batt_ok_i       (batt_ok_i),
  .drv_dom_o       (drv_dom_o),
  .rxd_force_low_o (rxd_force_low_o)
);

// File: tb/sim_lin_tx_gate.sv
module sim_lin_tx_gate;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int TO    = 4;
  localparam int NVEC  = 28;

  // {normal, therm, batt_low, batt_ok, txd[3:0], exp_drv[3:0], exp_rxd}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0000_1111_0000_0, // 0
    13'b1000_1111_0000_0, // 1
    13'b1000_1110_0001_0, // 2 fall ch0
    13'b1000_1110_0001_0, // 3
    13'b1000_1110_0001_0, // 4
    13'b1000_1110_0001_0, // 5
    13'b1000_1110_0000_0, // 6 timed out
    13'b1000_1111_0000_0, // 7
    13'b1000_1100_0011_0, // 8 fall ch0, ch1
    13'b1000_1100_0011_0, // 9
    13'b1000_1101_0010_0, // 10 ch0 high
    13'b1000_1100_0011_0, // 11 ch0 new fall
    13'b1000_1100_0001_0, // 12 ch1 out, ch0 runs
    13'b1100_1100_0000_1, // 13 thermal
    13'b1000_1100_0001_0, // 14 released
    13'b1000_1100_0000_0, // 15
    13'b1000_1111_0000_0, // 16
    13'b1010_1110_0000_0, // 17 batt low
    13'b1000_1110_0000_0, // 18 held
    13'b1001_1110_0000_0, // 19 recover seen
    13'b1000_1110_0001_0, // 20 allowed
    13'b1000_1111_0000_0, // 21
    13'b0000_1110_0000_0, // 22 not normal
    13'b1000_1110_0000_0, // 23 low at entry
    13'b1000_1110_0000_0, // 24
    13'b1000_1111_0000_0, // 25
    13'b1000_1110_0001_0, // 26
    13'b0000_1110_0000_0  // 27
  };

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           normal = 1'b0;
  logic [NCH-1:0] txd = '1;
  logic           therm = 1'b0;
  logic           blow = 1'b0;
  logic           bok = 1'b0;
  logic [NCH-1:0] drv;
  logic           rxl;
  int             n_chk = 0;
  int             n_fail = 0;
  bit             done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lin_tx_gate #(.N_CH(NCH), .TIMEOUT_CYC(TO)) u0 (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .normal_i        (normal),
    .txd_i           (txd),
    .therm_sd_i      (therm),
    .batt_low_i      (blow),
    .batt_ok_i       (bok),
    .drv_dom_o       (drv),
    .rxd_force_low_o (rxl)
  );

  function automatic string row_req(int r);
    if (r == 0 || r == 22 || r == 27) return "R8";
    if (r == 1 || (r >= 23 && r <= 26)) return "R2";
    if (r >= 2 && r <= 6) return "R3";
    if (r == 7 || r == 16) return "R4";
    if (r >= 8 && r <= 10) return "R1";
    if (r == 11 || r == 12) return "R10";
    if (r >= 13 && r <= 15) return "R5";
    if (r == 18) return "R7";
    return "R6";
  endfunction

  task automatic chk(string req, logic [NCH:0] act, logic [NCH:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual drv/rxd=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic n, logic th, logic bl, logic bo, logic [NCH-1:0] t);
    @(posedge clk);
    #1;
    normal = n; therm = th; blow = bl; bok = bo; txd = t;
    @(negedge clk);
  endtask

  initial begin
    // R9: reset state, rxd force follows thermal flag
    normal = 1'b1; txd = '0; therm = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", {drv, rxl}, 5'b0000_1);
    therm = 1'b0; normal = 1'b0; txd = '1;
    @(negedge clk);
    chk("R9", {drv, rxl}, 5'b0000_0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9", {drv, rxl}, 5'b0000_0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      chk(row_req(i), {drv, rxl}, VEC[i][4:0]);
    end

    // R1: ch2 stuck Low, ch3 keeps toggling
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'b1111);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'b1011);
    chk("R1", {drv, rxl}, 5'b0100_0);
    for (int k = 1; k < 10; k++) begin
      logic [NCH-1:0] e;
      step(1'b1, 1'b0, 1'b0, 1'b0, {((k % 2) == 1) ? 1'b0 : 1'b1, 3'b011});
      e = '0;
      e[3] = (k % 2) == 1;
      e[2] = k < TO;
      chk("R1", {drv, rxl}, {e, 1'b0});
    end

    // R6: block held while neither battery flag is set
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'b1111);
    step(1'b1, 1'b0, 1'b1, 1'b0, 4'b1111);
    chk("R6", {drv, rxl}, 5'b0000_0);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, ((k % 2) == 0) ? 4'b1110 : 4'b1111);
      chk("R7", {drv, rxl}, 5'b0000_0);
    end
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'b1111);
    chk("R6", {drv, rxl}, 5'b0000_0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'b1110);
    chk("R6", {drv, rxl}, 5'b0001_0);

    // R5: thermal release resumes at once on a fresh edge
    step(1'b1, 1'b1, 1'b0, 1'b0, 4'b1111);
    chk("R5", {drv, rxl}, 5'b0000_1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0111);
    chk("R5", {drv, rxl}, 5'b1000_0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule